// File: doc/BRIEF.md
# Timeslot serial audio byte packer

This block takes one serial audio data line, picked from four candidate pins, and turns it into bytes. Index 0 is the channel's own pin and indices 1 to 3 are pins shared with the neighbouring channel. On every bit strobe the selected line is shifted in, most significant bit first. When a timeslot ends, a two-bit slot command says where the byte goes. It can be packed into a 32-bit word, stored in a small four-byte feedback store, sent to both, or dropped.

Each destination keeps its own fill position. That position moves only when the destination takes a byte, so bytes land in the order they were latched. A word is complete when its last byte place is filled. It is then queued in a 24-entry FIFO that a consumer drains with a read strobe. A super-frame restart sends both fill positions back to the first place. A host register port can read the feedback store at any time. It can write the store only while the serial interface is idle, which lets control bytes be placed ahead of a frame and status bytes be collected after it.

Top module: `tslot_packer`

## Requirements
- R1: `line_sel` selects `sd_in[line_sel]`. Each cycle with `bit_en` high shifts that line in MSB first. A `slot_end` strobe (never in the same cycle as `bit_en`) captures the last 8 shifted bits as the slot byte.
- R2: At `slot_end`, bit 0 of `slot_cmd` sends the byte to the word packer and bit 1 sends it to the feedback store. Both bits set sends it to both, and 00 discards the byte.
- R3: Each destination fills its places in latch order. Its fill position advances only when it takes a byte. A discarded or diverted byte leaves the position unchanged.
- R4: With `big_endian` low, the k-th byte of a word (k = 0..3) occupies bits 8k+7..8k.
- R5: With `big_endian` high, the k-th byte of a word occupies bits 31-8k..24-8k.
- R6: Filling place 3 queues the word. `fifo_level` counts queued words. A `fifo_rd` with the FIFO non-empty presents the oldest word on `fifo_rdata` one cycle later, in first-in first-out order, and `fifo_empty` is high exactly when the level is 0.
- R7: A completed word that arrives while 24 words are queued is dropped. The level stays at 24 and `fifo_ovf` rises and stays high until reset.
- R8: `frame_start` returns both fill positions to place 0. A slot byte latched in the same cycle goes to place 0, and a partly filled word is abandoned.
- R9: The feedback store has 4 byte places. After place 3 it wraps back to place 0.
- R10: `hst_rdata` shows feedback place `hst_addr` one cycle after the address is applied, whether or not the interface is active.
- R11: `hst_wr` writes `hst_wdata` to place `hst_addr` only while `active` is low. While `active` is high it has no effect.
- R12: After reset, the FIFO is empty with level 0, `fifo_ovf` is low, both fill positions are at place 0, and every feedback place reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_in | input | 4 | Candidate serial lines (0 own, 1..3 shared) |
| line_sel | input | 2 | Index of the serial line to use |
| bit_en | input | 1 | Shift strobe, one per serial bit |
| slot_end | input | 1 | End-of-timeslot strobe |
| slot_cmd | input | 2 | Byte destination: bit0 word, bit1 feedback |
| frame_start | input | 1 | Super-frame start or restart |
| big_endian | input | 1 | Byte order inside a word |
| active | input | 1 | Serial interface running; blocks host writes |
| hst_wr | input | 1 | Host write strobe for the feedback store |
| hst_addr | input | 2 | Feedback place to access |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Registered feedback place contents |
| fifo_rd | input | 1 | Pop one word from the FIFO |
| fifo_rdata | output | 32 | Popped word |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_level | output | 5 | Number of queued words |
| fifo_ovf | output | 1 | Sticky word-dropped flag |

## Verification
A word completed at a `slot_end` edge shows in `fifo_level` and `fifo_ovf` two edges later: one register in the packer and one in the FIFO. The bench therefore idles two cycles after each slot before it looks. `fifo_rdata` and `hst_rdata` are due one edge after the strobe or address, so the bench applies the stimulus on a falling edge and samples on the next falling edge. Expected words and feedback contents come from a byte-by-byte arithmetic model that is swept over every line selection, both byte orders and rotating slot commands.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int CMD_TO_WORD = 0;
  localparam int CMD_TO_FB   = 1;

  function automatic int unsigned lane_of(input int unsigned pos, input int unsigned places,
                                          input logic msb_first);
    return msb_first ? (places - 1 - pos) : pos;
  endfunction
endpackage

// File: rtl/tsp_shifter.sv
module tsp_shifter #(
  parameter int LINES  = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  sd,
  input  logic [SEL_W-1:0]  sel,
  input  logic              bit_en,
  output logic [BYTE_W-1:0] shreg
);
  logic line_bit;
  assign line_bit = sd[sel];

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (bit_en) shreg <= {shreg[BYTE_W-2:0], line_bit};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> shreg[0] == $past(sd[sel]));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(shreg));
endmodule

// File: rtl/tsp_word_packer.sv
module tsp_word_packer #(
  parameter int BYTE_W = 8,
  parameter int PLACES = 4,
  localparam int PW = $clog2(PLACES),
  localparam int WORD_W = BYTE_W * PLACES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              restart,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] din,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  import tsp_pkg::*;

  logic [PW-1:0]     ptr, base;
  logic [WORD_W-1:0] asm_q, asm_next;

  assign base = restart ? '0 : ptr;

  always_comb begin
    asm_next = asm_q;
    asm_next[BYTE_W*lane_of(int'(base), PLACES, msb_first) +: BYTE_W] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      asm_q <= '0;
      push  <= 1'b0;
      word  <= '0;
    end else begin
      push <= 1'b0;
      if (latch) begin
        asm_q <= asm_next;
        if (int'(base) == PLACES - 1) begin
          ptr  <= '0;
          push <= 1'b1;
          word <= asm_next;
        end else begin
          ptr <= base + 1'b1;
        end
      end else begin
        ptr <= base;
      end
    end
  end

  // R3
  word_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch && !restart) |=> $stable(ptr));
  // R6
  word_push_src_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(latch));
endmodule

// File: rtl/tsp_feedback.sv
module tsp_feedback #(
  parameter int BYTE_W = 8,
  parameter int PLACES = 4,
  localparam int PW = $clog2(PLACES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              restart,
  input  logic [BYTE_W-1:0] din,
  input  logic              active,
  input  logic              hwr,
  input  logic [PW-1:0]     haddr,
  input  logic [BYTE_W-1:0] hwdata,
  output logic [BYTE_W-1:0] hrdata
);
  logic [BYTE_W-1:0] store [PLACES];
  logic [PW-1:0]     ptr, base;

  assign base = restart ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      hrdata <= '0;
      for (int i = 0; i < PLACES; i++) store[i] <= '0;
    end else begin
      hrdata <= store[haddr];
      if (latch) begin
        store[base] <= din;
        ptr <= (int'(base) == PLACES - 1) ? '0 : base + 1'b1;
      end else begin
        ptr <= base;
        if (hwr && !active) store[haddr] <= hwdata;
      end
    end
  end

  for (genvar g = 0; g < PLACES; g++) begin : g_hold
    // R11
    fb_host_block_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !latch) |=> $stable(store[g]));
  end
  // R3
  fb_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch && !restart) |=> $stable(ptr));
endmodule

// File: rtl/tsp_fifo.sv
module tsp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 24,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic [LW-1:0] level,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd, full;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
    if (do_rd) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(do_wr) - LW'(do_rd);
      if (push && full) ovf <= 1'b1;
    end
  end

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: rtl/tslot_packer.sv
module tslot_packer #(
  parameter int LINES      = 4,
  parameter int BYTE_W     = 8,
  parameter int PLACES     = 4,
  parameter int FIFO_DEPTH = 24,
  localparam int SEL_W  = $clog2(LINES),
  localparam int PW     = $clog2(PLACES),
  localparam int WORD_W = BYTE_W * PLACES,
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  sd_in,
  input  logic [SEL_W-1:0]  line_sel,
  input  logic              bit_en,
  input  logic              slot_end,
  input  logic [1:0]        slot_cmd,
  input  logic              frame_start,
  input  logic              big_endian,
  input  logic              active,
  input  logic              hst_wr,
  input  logic [PW-1:0]     hst_addr,
  input  logic [BYTE_W-1:0] hst_wdata,
  output logic [BYTE_W-1:0] hst_rdata,
  input  logic              fifo_rd,
  output logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_empty,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_ovf
);
  import tsp_pkg::*;

  logic [BYTE_W-1:0] slot_byte;
  logic              word_push;
  logic [WORD_W-1:0] word_val;
  logic              to_word, to_fb;

  assign to_word = slot_end && slot_cmd[CMD_TO_WORD];
  assign to_fb   = slot_end && slot_cmd[CMD_TO_FB];

  tsp_shifter #(.LINES(LINES), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .sd(sd_in), .sel(line_sel), .bit_en(bit_en), .shreg(slot_byte));

  tsp_word_packer #(.BYTE_W(BYTE_W), .PLACES(PLACES)) u_pack (
    .clk(clk), .rst(rst), .latch(to_word), .restart(frame_start), .msb_first(big_endian),
    .din(slot_byte), .push(word_push), .word(word_val));

  tsp_feedback #(.BYTE_W(BYTE_W), .PLACES(PLACES)) u_fb (
    .clk(clk), .rst(rst), .latch(to_fb), .restart(frame_start), .din(slot_byte),
    .active(active), .hwr(hst_wr), .haddr(hst_addr), .hwdata(hst_wdata), .hrdata(hst_rdata));

  tsp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(word_push), .wdata(word_val), .pop(fifo_rd),
    .rdata(fifo_rdata), .empty(fifo_empty), .level(fifo_level), .ovf(fifo_ovf));

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && slot_end));
endmodule

// File: tb/tslot_packer_bench.sv
module tslot_packer_bench;
  logic clk = 0, rst = 1;
  logic [3:0] sd_in = 0;
  logic [1:0] line_sel = 0, slot_cmd = 0, hst_addr = 0;
  logic bit_en = 0, slot_end = 0, frame_start = 0, big_endian = 0, active = 0;
  logic hst_wr = 0, fifo_rd = 0;
  logic [7:0] hst_wdata = 0, hst_rdata;
  logic [31:0] fifo_rdata;
  logic fifo_empty, fifo_ovf;
  logic [4:0] fifo_level;

  tslot_packer u_tslot_packer (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0]  m_fb [4];
  int          m_fbp = 0, m_dwp = 0, qh = 0, qt = 0;
  logic [31:0] m_word = 0;
  logic [31:0] q [256];
  logic        m_ovf = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b, input logic [1:0] cmd, input bit fs);
    int p;
    if (fs) begin m_dwp = 0; m_fbp = 0; end
    if (cmd[0]) begin
      p = m_dwp;
      if (big_endian) m_word[8*(3-p) +: 8] = b; else m_word[8*p +: 8] = b;
      if (p == 3) begin
        if (qt - qh < 24) begin q[qt % 256] = m_word; qt++; end
        else m_ovf = 1;
        m_dwp = 0;
      end else m_dwp = p + 1;
    end
    if (cmd[1]) begin m_fb[m_fbp] = b; m_fbp = (m_fbp + 1) % 4; end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [1:0] cmd, input bit fs);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sd_in = {4{~b[i]}};
      sd_in[line_sel] = b[i];
      bit_en = 1;
    end
    @(negedge clk);
    bit_en = 0; slot_end = 1; slot_cmd = cmd; frame_start = fs;
    @(negedge clk);
    slot_end = 0; slot_cmd = 0; frame_start = 0;
    @(negedge clk);
    model_byte(b, cmd, fs);
  endtask

  task automatic restart_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    m_dwp = 0; m_fbp = 0;
  endtask

  task automatic drain(input string req);
    while (qt > qh) begin
      @(negedge clk); fifo_rd = 1;
      @(negedge clk); fifo_rd = 0;
      chk(req, fifo_rdata, q[qh % 256]);
      qh++;
    end
    @(negedge clk);
    chk("R6 level after drain", 32'(fifo_level), 0);
    chk("R6 empty after drain", 32'(fifo_empty), 1);
  endtask

  task automatic host_read(input int a, input string req);
    @(negedge clk); hst_addr = 2'(a);
    @(negedge clk);
    chk(req, 32'(hst_rdata), 32'(m_fb[a]));
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = 2'(a); hst_wdata = d;
    @(negedge clk); hst_wr = 0;
    if (!active) m_fb[a] = d;
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_fb[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 level", 32'(fifo_level), 0);
    chk("R12 empty", 32'(fifo_empty), 1);
    chk("R12 ovf", 32'(fifo_ovf), 0);
    for (int a = 0; a < 4; a++) host_read(a, "R12 feedback zero");

    // Sweep: byte order x line x rotating commands (R1 R2 R3 R4 R5 R9 R10)
    for (int be = 0; be < 2; be++) begin
      for (int s = 0; s < 4; s++) begin
        big_endian = be[0]; line_sel = 2'(s); active = 1;
        restart_frame();
        for (int i = 0; i < 40; i++)
          send_byte(8'(i * 37 + be * 11 + s * 5 + 8'h5A), 2'((i * 3 + s + be) % 4), 0);
        chk("R6 level", 32'(fifo_level), 32'(qt - qh));
        drain(be ? "R5 R1 R2 R3 word" : "R4 R1 R2 R3 word");
        for (int a = 0; a < 4; a++) host_read(a, "R9 R10 R3 feedback");
      end
    end

    // Restart mid-word, with a byte in the same cycle (R8)
    big_endian = 0; line_sel = 0; restart_frame();
    send_byte(8'hA1, 2'b11, 0);
    send_byte(8'hB2, 2'b11, 0);
    send_byte(8'hC3, 2'b11, 1);
    send_byte(8'hD4, 2'b11, 0);
    send_byte(8'hE5, 2'b11, 0);
    send_byte(8'hF6, 2'b11, 0);
    chk("R8 one word queued", 32'(fifo_level), 1);
    drain("R8 word after restart");
    host_read(0, "R8 feedback place 0");
    host_read(3, "R8 feedback place 3");

    // Host writes blocked while active (R11)
    active = 1;
    host_write(1, 8'h3C);
    host_read(1, "R11 write ignored while active");
    active = 0;
    host_write(1, 8'h77);
    host_write(2, 8'h88);
    host_read(1, "R11 write while idle");
    host_read(2, "R11 write while idle");

    // Overflow (R7)
    active = 1; restart_frame();
    for (int i = 0; i < 100; i++) send_byte(8'(i * 13 + 1), 2'b01, 0);
    chk("R7 level capped", 32'(fifo_level), 24);
    chk("R7 ovf set", 32'(fifo_ovf), 32'(m_ovf));
    drain("R7 R6 kept words in order");
    chk("R7 ovf sticky", 32'(fifo_ovf), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule